// File: doc/BRIEF.md
# Crystal clock-loss guard with limp-home fallback

This block watches a crystal-derived clock from the domain of a free-running backup clock. The crystal signal is brought in through a synchronizer, and its rising edges are counted. The block decides whether the crystal has gone quiet and whether it has become stable again. When the crystal stops, the block does one of two things, chosen by a software control bit. It can request a clock-monitor reset and then hold reset until the crystal has proven stable. Or it can steer the system clock to a limp-home source, without any reset, and steer it back to the PLL once the crystal is stable again and the PLL reports lock.

The clock steering is a registered select output that drives a separate glitch-free clock mux, so the processor keeps running across the switch. Each entry into and each exit from limp-home sets a sticky flag. Software clears that flag with a one-cycle clear strobe. There is no streaming data path: every pin is a plain control or status level, or a single-cycle strobe.

Top module: `cm_clk_guard`

## Requirements
- R1: While `rst_n` is low, and after release until the crystal is stable, `rst_hold` is 1 and `clk_sel`, `cm_rst_req` and `lh_flag` are 0.
- R2: After reset, `rst_hold` falls once STABLE_EDGES consecutive crystal rising edges have been counted, with no gap of LOSS_WIN backup cycles between them.
- R3: A crystal loss is declared when LOSS_WIN backup cycles pass with no crystal rising edge. Edges spaced exactly LOSS_WIN cycles apart never cause a loss.
- R4: With `lh_disable` = 0, a loss in normal running sets `clk_sel` to 1 (1 = limp-home source, 0 = PLL clock). In that case `cm_rst_req` is never asserted.
- R5: In limp-home, `clk_sel` returns to 0 only when STABLE_EDGES consecutive crystal edges have been counted and `pll_lock` is 1. It stays 1 while `pll_lock` is 0.
- R6: `lh_flag` is set in the same cycle that `clk_sel` changes, both on entry to limp-home and on exit from it, and at no other time.
- R7: A one-cycle `flag_clr` strobe clears `lh_flag`. If a set event falls in the same cycle, the set wins and the flag ends at 1.
- R8: With `lh_disable` = 1, a loss in normal running gives a `cm_rst_req` pulse exactly one cycle wide and raises `rst_hold` in the same cycle. `clk_sel` and `lh_flag` do not change.
- R9: After a clock-monitor reset request, `rst_hold` stays 1 until STABLE_EDGES consecutive crystal edges have been counted, and falls right after that.
- R10: `clk_sel` is never 1 while `rst_hold` is 1, so the clock switch never happens under reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bk | input | 1 | Free-running backup clock; all logic runs on it |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| xtal_in | input | 1 | Crystal clock activity, asynchronous to clk_bk |
| pll_lock | input | 1 | PLL lock indication |
| lh_disable | input | 1 | 1: a crystal loss requests reset; 0: a crystal loss falls back to limp-home |
| flag_clr | input | 1 | One-cycle strobe that clears lh_flag |
| clk_sel | output | 1 | Clock-mux select: 1 = limp-home source, 0 = PLL clock |
| cm_rst_req | output | 1 | One-cycle clock-monitor reset request |
| rst_hold | output | 1 | Holds system reset until the crystal is stable |
| lh_flag | output | 1 | Sticky limp-home transition flag |

## Verification
Take the backup cycle in which the bench drives a crystal rising edge, and call it c. The edge is counted at the clock edge c+3: two synchronizer stages plus one edge register. A state change that this edge causes shows on the outputs at c+4. A loss that follows the last edge at c shows at c+4+LOSS_WIN, and the end of the reset request shows one cycle after that. A `flag_clr` strobe or a `pll_lock` change applied in cycle e takes effect at e+1. The bench works out each of these due cycles from the cycle it drove, and pushes the expected output transition with that cycle into a scoreboard queue. A monitor samples the outputs on the falling clock edge and pops one entry for every transition it sees. An early, late, extra or missing transition therefore shows up as a mismatch.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic [1:0] {
    CM_BOOT = 2'd0,
    CM_RUN  = 2'd1,
    CM_LIMP = 2'd2,
    CM_HOLD = 2'd3
  } cm_state_e;
endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_bk,
  input  logic rst_n,
  input  logic xtal_in,
  output logic rise_pulse
);
  // synchronizer stages plus one history register
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_bk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], xtal_in};
  end

  assign rise_pulse = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
endmodule

// File: rtl/cm_activity_mon.sv
module cm_activity_mon #(
  parameter int LOSS_WIN     = 64,
  parameter int STABLE_EDGES = 4096
) (
  input  logic clk_bk,
  input  logic rst_n,
  input  logic rise_pulse,
  output logic lost,
  output logic stable
);
  localparam int GW = $clog2(LOSS_WIN + 1);
  localparam int SW = $clog2(STABLE_EDGES + 1);
  localparam logic [GW-1:0] GAP_MAX = GW'(LOSS_WIN);
  localparam logic [SW-1:0] RUN_MAX = SW'(STABLE_EDGES);

  logic [GW-1:0] gap_q;
  logic [SW-1:0] run_q;

  // cycles since the last crystal edge, saturating at the loss window
  always_ff @(posedge clk_bk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (rise_pulse)       gap_q <= '0;
    else if (gap_q != GAP_MAX) gap_q <= gap_q + GW'(1);
  end

  // consecutive edges without a loss in between, saturating
  always_ff @(posedge clk_bk or negedge rst_n) begin
    if (!rst_n)                                run_q <= '0;
    else if (rise_pulse && run_q != RUN_MAX)   run_q <= run_q + SW'(1);
    else if (!rise_pulse && gap_q == GAP_MAX)  run_q <= '0;
  end

  assign lost   = (gap_q == GAP_MAX);
  assign stable = (run_q == RUN_MAX);
endmodule

// File: rtl/cm_mode_fsm.sv
module cm_mode_fsm
  import cm_pkg::*;
(
  input  logic clk_bk,
  input  logic rst_n,
  input  logic lost,
  input  logic stable,
  input  logic pll_lock,
  input  logic lh_disable,
  output logic clk_sel,
  output logic cm_rst_req,
  output logic rst_hold,
  output logic lh_event
);
  cm_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    lh_event = 1'b0;
    unique case (state_q)
      CM_BOOT, CM_HOLD: if (stable) state_d = CM_RUN;
      CM_RUN: begin
        if (lost) begin
          if (lh_disable) state_d = CM_HOLD;
          else begin
            state_d  = CM_LIMP;
            lh_event = 1'b1;
          end
        end
      end
      CM_LIMP: begin
        if (stable && pll_lock) begin
          state_d  = CM_RUN;
          lh_event = 1'b1;
        end
      end
      default: state_d = CM_BOOT;
    endcase
  end

  // registered outputs feed the external glitch-free mux and reset logic
  always_ff @(posedge clk_bk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CM_BOOT;
      clk_sel    <= 1'b0;
      rst_hold   <= 1'b1;
      cm_rst_req <= 1'b0;
    end else begin
      state_q    <= state_d;
      clk_sel    <= (state_d == CM_LIMP);
      rst_hold   <= (state_d == CM_BOOT) || (state_d == CM_HOLD);
      cm_rst_req <= (state_q == CM_RUN) && lost && lh_disable;
    end
  end
endmodule

// File: rtl/cm_flag.sv
module cm_flag (
  input  logic clk_bk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_strobe,
  output logic flag_q
);
  always_ff @(posedge clk_bk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (set_evt)    flag_q <= 1'b1;
    else if (clr_strobe) flag_q <= 1'b0;
  end
endmodule

// File: rtl/cm_clk_guard.sv
module cm_clk_guard #(
  parameter int LOSS_WIN     = 64,
  parameter int STABLE_EDGES = 4096,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_bk,
  input  logic rst_n,
  input  logic xtal_in,
  input  logic pll_lock,
  input  logic lh_disable,
  input  logic flag_clr,
  output logic clk_sel,
  output logic cm_rst_req,
  output logic rst_hold,
  output logic lh_flag
);
  logic rise_pulse, lost, stable, lh_event;

  cm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_bk(clk_bk), .rst_n(rst_n), .xtal_in(xtal_in), .rise_pulse(rise_pulse)
  );

  cm_activity_mon #(.LOSS_WIN(LOSS_WIN), .STABLE_EDGES(STABLE_EDGES)) u_mon (
    .clk_bk(clk_bk), .rst_n(rst_n), .rise_pulse(rise_pulse),
    .lost(lost), .stable(stable)
  );

  cm_mode_fsm u_fsm (
    .clk_bk(clk_bk), .rst_n(rst_n), .lost(lost), .stable(stable),
    .pll_lock(pll_lock), .lh_disable(lh_disable), .clk_sel(clk_sel),
    .cm_rst_req(cm_rst_req), .rst_hold(rst_hold), .lh_event(lh_event)
  );

  cm_flag u_flag (
    .clk_bk(clk_bk), .rst_n(rst_n), .set_evt(lh_event),
    .clr_strobe(flag_clr), .flag_q(lh_flag)
  );
endmodule

// File: rtl/cm_clk_guard_chk.sv
module cm_clk_guard_chk (
  input logic clk_bk,
  input logic rst_n,
  input logic lh_disable,
  input logic clk_sel,
  input logic cm_rst_req,
  input logic rst_hold,
  input logic lh_flag
);
  // R4: a reset request only ever follows a cycle with lh_disable high
  p_req_only_when_disabled_r4: assert property (@(posedge clk_bk) disable iff (!rst_n)
    cm_rst_req |-> $past(lh_disable));

  // R8: the request is a single-cycle pulse
  p_req_one_cycle_r8: assert property (@(posedge clk_bk) disable iff (!rst_n)
    cm_rst_req |=> !cm_rst_req);

  // R8: reset hold comes up together with the request
  p_req_with_hold_r8: assert property (@(posedge clk_bk) disable iff (!rst_n)
    cm_rst_req |-> rst_hold);

  // R10: limp-home selection never overlaps a held reset
  p_sel_hold_exclusive_r10: assert property (@(posedge clk_bk) disable iff (!rst_n)
    !(clk_sel && rst_hold));

  // R6: every switch of the clock select leaves the flag set
  p_sel_change_flags_r6: assert property (@(posedge clk_bk) disable iff (!rst_n)
    (clk_sel != $past(clk_sel)) |-> lh_flag);

  // R6: the flag rises only with a switch
  p_flag_rise_on_switch_r6: assert property (@(posedge clk_bk) disable iff (!rst_n)
    $rose(lh_flag) |-> (clk_sel != $past(clk_sel)));
endmodule

bind cm_clk_guard cm_clk_guard_chk u_chk (
  .clk_bk(clk_bk), .rst_n(rst_n), .lh_disable(lh_disable), .clk_sel(clk_sel),
  .cm_rst_req(cm_rst_req), .rst_hold(rst_hold), .lh_flag(lh_flag)
);

// File: tb/cm_clk_guard_test.sv
module cm_clk_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int S = 32;
  localparam int WATCHDOG = 20000;

  logic clk_bk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_in = 1'b0;
  logic pll_lock = 1'b0;
  logic lh_disable = 1'b0;
  logic flag_clr = 1'b0;
  logic clk_sel, cm_rst_req, rst_hold, lh_flag;

  cm_clk_guard #(.LOSS_WIN(W), .STABLE_EDGES(S), .SYNC_STAGES(2)) uut (
    .clk_bk(clk_bk), .rst_n(rst_n), .xtal_in(xtal_in), .pll_lock(pll_lock),
    .lh_disable(lh_disable), .flag_clr(flag_clr), .clk_sel(clk_sel),
    .cm_rst_req(cm_rst_req), .rst_hold(rst_hold), .lh_flag(lh_flag)
  );

  always #(CLK_PERIOD/2) clk_bk = ~clk_bk;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int req_pulses = 0;
  int overlap = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic p_hold, p_sel, p_req, p_flag;

  always @(posedge clk_bk) cyc <= cyc + 1;

  typedef enum int {
    EV_HOLD_FALL, EV_HOLD_RISE, EV_SEL_RISE, EV_SEL_FALL,
    EV_REQ_RISE, EV_REQ_FALL, EV_FLAG_RISE, EV_FLAG_FALL
  } ev_e;
  typedef struct { ev_e kind; int cyc; string req; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input ev_e k, input int c, input string r);
    exp_t e;
    e.kind = k; e.cyc = c; e.req = r;
    sb.push_back(e);
  endtask

  task automatic observe(input ev_e k);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      fails++;
      $display("FAIL unexpected %s at cycle %0d: actual event expected none",
               k.name(), cyc);
    end else begin
      e = sb.pop_front();
      if (e.kind != k || e.cyc != cyc) begin
        fails++;
        $display("FAIL %s: actual %s at cycle %0d expected %s at cycle %0d",
                 e.req, k.name(), cyc, e.kind.name(), e.cyc);
      end
    end
  endtask

  // monitor: sample away from the active edge, report every output transition
  always @(negedge clk_bk) begin
    if (mon_on) begin
      if (rst_hold !== p_hold) observe(rst_hold ? EV_HOLD_RISE : EV_HOLD_FALL);
      if (clk_sel  !== p_sel)  observe(clk_sel  ? EV_SEL_RISE  : EV_SEL_FALL);
      if (cm_rst_req !== p_req) begin
        observe(cm_rst_req ? EV_REQ_RISE : EV_REQ_FALL);
        if (cm_rst_req) req_pulses++;
      end
      if (lh_flag !== p_flag) observe(lh_flag ? EV_FLAG_RISE : EV_FLAG_FALL);
      if (clk_sel && rst_hold) overlap++;
      p_hold = rst_hold; p_sel = clk_sel; p_req = cm_rst_req; p_flag = lh_flag;
    end
  end

  // crystal rising edges every 2*h backup cycles; returns cycle of last rise
  task automatic run_edges(input int n, input int h, output int last);
    last = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_bk);
      xtal_in = 1'b1;
      last = cyc;
      repeat (h) @(negedge clk_bk);
      xtal_in = 1'b0;
      repeat (h - 1) @(negedge clk_bk);
    end
  endtask

  initial begin
    int c;
    int e;
    repeat (3) @(negedge clk_bk);
    // R1: reset state
    chk(rst_hold == 1'b1, "R1", "rst_hold in reset", rst_hold, 1);
    chk(clk_sel == 1'b0, "R1", "clk_sel in reset", clk_sel, 0);
    chk(cm_rst_req == 1'b0, "R1", "cm_rst_req in reset", cm_rst_req, 0);
    chk(lh_flag == 1'b0, "R1", "lh_flag in reset", lh_flag, 0);
    rst_n = 1'b1;
    p_hold = rst_hold; p_sel = clk_sel; p_req = cm_rst_req; p_flag = lh_flag;
    mon_on = 1'b1;
    repeat (5) @(negedge clk_bk);
    chk(rst_hold == 1'b1, "R1", "rst_hold before crystal stable", rst_hold, 1);

    // R2: boot release after S edges
    run_edges(S, 2, c);
    expect_ev(EV_HOLD_FALL, c + 4, "R2");
    // R3: edges spaced exactly W apart: no loss
    run_edges(20, W/2, c);
    chk(clk_sel == 1'b0, "R3", "clk_sel with edges W apart", clk_sel, 0);

    // R4/R6: loss with limp-home enabled
    expect_ev(EV_SEL_RISE, c + 4 + W, "R4");
    expect_ev(EV_FLAG_RISE, c + 4 + W, "R6");
    repeat (W + 12) @(negedge clk_bk);
    chk(clk_sel == 1'b1, "R4", "clk_sel after loss", clk_sel, 1);
    chk(req_pulses == 0, "R4", "reset requests with limp-home", req_pulses, 0);
    chk(rst_hold == 1'b0, "R4", "rst_hold in limp-home", rst_hold, 0);

    // R7: clear strobe
    flag_clr = 1'b1;
    expect_ev(EV_FLAG_FALL, cyc + 1, "R7");
    @(negedge clk_bk);
    flag_clr = 1'b0;
    chk(lh_flag == 1'b0, "R7", "lh_flag after clear", lh_flag, 0);

    // R5: crystal back but no lock: stay in limp-home
    run_edges(S + 4, 2, c);
    chk(clk_sel == 1'b1, "R5", "clk_sel without pll_lock", clk_sel, 1);

    // R5/R6/R7: lock arrives together with a clear strobe; set wins
    e = cyc;
    pll_lock = 1'b1;
    flag_clr = 1'b1;
    expect_ev(EV_SEL_FALL, e + 1, "R5");
    expect_ev(EV_FLAG_RISE, e + 1, "R7");
    @(negedge clk_bk);
    flag_clr = 1'b0;
    run_edges(6, 2, c);
    chk(clk_sel == 1'b0, "R5", "clk_sel after lock", clk_sel, 0);
    chk(lh_flag == 1'b1, "R7", "set beats clear", lh_flag, 1);
    flag_clr = 1'b1;
    expect_ev(EV_FLAG_FALL, cyc + 1, "R7");
    @(negedge clk_bk);
    flag_clr = 1'b0;

    // R8: loss with limp-home disabled
    lh_disable = 1'b1;
    run_edges(4, 2, c);
    expect_ev(EV_HOLD_RISE, c + 4 + W, "R8");
    expect_ev(EV_REQ_RISE, c + 4 + W, "R8");
    expect_ev(EV_REQ_FALL, c + 5 + W, "R8");
    repeat (W + 10) @(negedge clk_bk);
    chk(req_pulses == 1, "R8", "reset request pulses", req_pulses, 1);
    chk(clk_sel == 1'b0, "R8", "clk_sel unchanged", clk_sel, 0);
    chk(lh_flag == 1'b0, "R8", "lh_flag unchanged", lh_flag, 0);
    chk(rst_hold == 1'b1, "R8", "rst_hold after request", rst_hold, 1);

    // R9: hold until S consecutive edges
    run_edges(S - 1, 2, c);
    chk(rst_hold == 1'b1, "R9", "rst_hold after S-1 edges", rst_hold, 1);
    run_edges(1, 2, c);
    expect_ev(EV_HOLD_FALL, c + 4, "R9");
    run_edges(5, 2, c);
    chk(rst_hold == 1'b0, "R9", "rst_hold after S edges", rst_hold, 0);

    // R10: no overlap of limp-home select and reset hold
    chk(overlap == 0, "R10", "cycles with clk_sel and rst_hold", overlap, 0);
    chk(sb.size() == 0, "R2", "missing expected transitions", sb.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (WATCHDOG) @(posedge clk_bk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule